// File: doc/BRIEF.md
# Constant Reciprocal Divider by Fourteen

This block produces an approximate quotient of an unsigned operand divided by the fixed value 14 without an iterative divider. The operand is multiplied by a 17-bit scaled reciprocal, 17'h12492, which is 2^20/14 rounded to an integer. The quotient is taken as the product shifted right by 20 places. A single register stage holds the quotient, so a result appears one clock after its operand is presented.

The reciprocal is slightly smaller than the true 2^20/14. The quotient can therefore fall short of the exact floor(x/14), and the shortfall grows with the size of the operand. It never overshoots. Users that need an exact result on large operands must widen the reciprocal. That may cost more than one multiply. The operand width is a parameter (default 24 bits), and the quotient is three bits narrower than the operand.

Top module: `dv14_recip_div`

## Requirements
- R1: While the reset input `rst_n` is low, `out_vld` is 0 and `out_quo` is 0. The reset takes effect at once and is released on the second rising clock edge after `rst_n` goes high.
- R2: `out_vld` equals the value `in_vld` had on the previous rising clock edge.
- R3: When `in_vld` is 1 on a rising edge with operand x, `out_quo` equals floor(x * 74898 / 2^20) after that edge, where 74898 is 17'h12492.
- R4: Every result is at most floor(x/14) and at least floor(x/14) - (ceil(x/2^21) + 1).
- R5: The operand 24'h96B43A gives the quotient 20'hAC3B8, not the exact 20'hAC3BB.
- R6: While `in_vld` is 0, `out_quo` keeps its last value, whatever `in_data` holds.
- R7: The all-ones 24-bit operand 24'hFFFFFF gives 1198367 with no wrap of the product.
- R8: The operand 0 gives the quotient 0.
- R9: Operands presented on consecutive cycles each give their own result on the following cycle, with no gap.

Parameter `W` sets the operand width. It must be at least 4. Each row of the port table below gives its width in terms of `W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| in_vld | input | 1 | Operand strobe; also the clock enable of the quotient register |
| in_data | input | W | Unsigned dividend |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| out_quo | output | W-3 | Approximate quotient, held between strobes |

## Verification
A wrong reciprocal bit or a wrong shift shows at `out_quo` on the first strobe after the operand. It appears either as a break from the exact floor(x*74898/2^20) or as a value outside the error window around floor(x/14). Large operands make such faults stand out most clearly.

A fault in the enable of the quotient register shows the next cycle as a changed value while `in_vld` is low. A fault in the strobe stage shows as `out_vld` out of step with `in_vld` by the next edge. A reset fault shows at once as nonzero outputs while `rst_n` is low.

// File: rtl/dv14_pkg.sv
package dv14_pkg;
  // Scaled reciprocal of 14: round(2^20 / 14), held to 17 bits
  localparam int unsigned RECIP_W = 17;
  localparam logic [RECIP_W-1:0] RECIP = 17'h12492;
  localparam int unsigned SHIFT = 20;
  // Width lost from the operand when forming the quotient
  localparam int unsigned QUO_LOSS = SHIFT - RECIP_W;
  // Multiplier build choice
  typedef enum logic [0:0] {
    MUL_NATIVE   = 1'b0,
    MUL_SHIFTADD = 1'b1
  } mul_impl_e;
endpackage

// File: rtl/dv14_rst_sync.sv
module dv14_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dv14_recip_mult.sv
module dv14_recip_mult
  import dv14_pkg::*;
#(
  parameter int unsigned W        = 24,
  parameter mul_impl_e   MUL_IMPL = MUL_NATIVE,
  localparam int unsigned PW      = W + RECIP_W,
  localparam int unsigned QW      = W - QUO_LOSS
) (
  input  logic [W-1:0]  din,
  output logic [QW-1:0] quo
);
  logic [PW-1:0] prod;

  generate
    if (MUL_IMPL == MUL_NATIVE) begin : g_native
      always_comb begin
        prod = PW'(din) * PW'(RECIP);
      end
    end else begin : g_shiftadd
      // Sum of operand copies at the set bit positions of the constant
      logic [PW-1:0] acc [0:RECIP_W];
      assign acc[0] = '0;
      for (genvar j = 0; j < RECIP_W; j++) begin : g_bit
        if (RECIP[j]) begin : g_set
          assign acc[j+1] = acc[j] + (PW'(din) << j);
        end else begin : g_clr
          assign acc[j+1] = acc[j];
        end
      end
      always_comb begin
        prod = acc[RECIP_W];
      end
    end
  endgenerate

  assign quo = QW'(prod >> SHIFT);
endmodule

// File: rtl/dv14_en_reg.sv
module dv14_en_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (en) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end
endmodule

// File: rtl/dv14_recip_div.sv
module dv14_recip_div
  import dv14_pkg::*;
#(
  parameter int unsigned W        = 24,
  parameter mul_impl_e   MUL_IMPL = MUL_NATIVE,
  localparam int unsigned QW      = W - QUO_LOSS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [W-1:0]  in_data,
  output logic          out_vld,
  output logic [QW-1:0] out_quo
);
  logic          srst_n;
  logic [QW-1:0] quo_c;

  dv14_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dv14_recip_mult #(.W(W), .MUL_IMPL(MUL_IMPL)) u_mult (
    .din (in_data),
    .quo (quo_c)
  );

  // Quotient register loads only on a strobe
  dv14_en_reg #(.WIDTH(QW)) u_quo (
    .clk    (clk),
    .srst_n (srst_n),
    .en     (in_vld),
    .d      (quo_c),
    .q      (out_quo)
  );

  // Strobe register always enabled
  dv14_en_reg #(.WIDTH(1)) u_vld (
    .clk    (clk),
    .srst_n (srst_n),
    .en     (1'b1),
    .d      (in_vld),
    .q      (out_vld)
  );
endmodule

// File: rtl/dv14_recip_div_chk.sv
module dv14_recip_div_chk #(
  parameter int unsigned W  = 24,
  localparam int unsigned QW = W - 3,
  localparam int unsigned XW = W + 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_vld,
  input logic [W-1:0]  in_data,
  input logic          out_vld,
  input logic [QW-1:0] out_quo
);
  // Counts edges since reset release so past values are from after release
  logic [1:0] live_cnt;
  logic       live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_cnt <= 2'd0;
    end else if (live_cnt != 2'd3) begin
      live_cnt <= live_cnt + 2'd1;
    end
  end

  assign live = (live_cnt == 2'd3);

  logic [XW-1:0] quo_x14;
  logic [XW-1:0] approx;
  assign quo_x14 = XW'(out_quo) * XW'(14);
  assign approx  = (XW'(in_data) * XW'(17'h12492)) >> 20;

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_clear : assert (out_vld == 1'b0 && out_quo == '0);
    end
  end

  a_r2_valid_delay : assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (out_vld == $past(in_vld)));

  a_r3_recip_value : assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_vld) |=> (XW'(out_quo) == $past(approx)));

  a_r4_no_overshoot : assert property (@(posedge clk) disable iff (!rst_n)
    (live && in_vld) |=> (quo_x14 <= XW'($past(in_data))));

  a_r6_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
    (live && !in_vld) |=> $stable(out_quo));
endmodule

bind dv14_recip_div dv14_recip_div_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_vld  (in_vld),
  .in_data (in_data),
  .out_vld (out_vld),
  .out_quo (out_quo)
);

// File: tb/dv14_recip_div_test.sv
module dv14_recip_div_test;
  localparam int unsigned W  = 24;
  localparam int unsigned QW = W - 3;
  localparam int NV = 9;

  localparam logic [W-1:0] VX [0:NV-1] = '{
    24'd0, 24'd13, 24'd14, 24'd140, 24'd1000,
    24'h96B43A, 24'hFFFFFF, 24'h800000, 24'h555555};
  localparam logic [W-1:0] VEXACT [0:NV-1] = '{
    24'd0, 24'd0, 24'd1, 24'd10, 24'd71,
    24'd705467, 24'd1198372, 24'd599186, 24'd399457};

  logic          clk;
  logic          rst_n;
  logic          in_vld;
  logic [W-1:0]  in_data;
  logic          out_vld;
  logic [QW-1:0] out_quo;

  int checks = 0;
  int errors = 0;

  dv14_recip_div #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .out_vld(out_vld), .out_quo(out_quo));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Checks the result for operand x against R3 and R4
  task automatic chk_result(input logic [W-1:0] x, input longint exact);
    longint unsigned approx, tol, short;
    approx = (longint'(x) * 74898) >> 20;
    tol    = ((longint'(x) + (64'd1 << 21) - 1) >> 21) + 1;
    chk("R2 out_vld after strobe", longint'(out_vld), 1);
    chk("R3 reciprocal quotient", longint'(out_quo), longint'(approx));
    checks++;
    short = exact - longint'(out_quo);
    if (longint'(out_quo) > exact || short > tol) begin
      errors++;
      $display("FAIL R4 window actual=%0d expected=%0d..%0d",
               out_quo, exact - longint'(tol), exact);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    in_vld = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_vld", longint'(out_vld), 0);
    chk("R1 reset out_quo", longint'(out_quo), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 idle out_vld", longint'(out_vld), 0);

    // Table walk, back-to-back strobes (R9)
    for (int i = 0; i <= NV; i++) begin
      if (i > 0) begin
        chk_result(VX[i-1], longint'(VEXACT[i-1]));
        if (i == 1) chk("R8 zero operand", longint'(out_quo), 0);
        if (i == 6) chk("R5 example operand", longint'(out_quo), 64'hAC3B8);
        if (i == 7) chk("R7 all-ones operand", longint'(out_quo), 1198367);
        if (i > 1) chk("R9 consecutive strobe", longint'(out_vld), 1);
      end
      if (i < NV) begin
        in_vld = 1'b1;
        in_data = VX[i];
      end else begin
        in_vld = 1'b0;
      end
      @(negedge clk);
    end
    chk("R2 strobe dropped", longint'(out_vld), 0);

    // Hold while idle (R6)
    in_vld = 1'b1;
    in_data = 24'h96B43A;
    @(negedge clk);
    chk("R5 single strobe", longint'(out_quo), 64'hAC3B8);
    in_vld = 1'b0;
    in_data = 24'hFFFFFF;
    repeat (3) @(negedge clk);
    chk("R6 hold out_quo", longint'(out_quo), 64'hAC3B8);
    chk("R2 idle after hold", longint'(out_vld), 0);

    // Isolated strobe after idle, then mid-run reset (R1)
    in_vld = 1'b1;
    in_data = 24'd28;
    @(negedge clk);
    in_vld = 1'b0;
    chk_result(24'd28, 2);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async clear out_vld", longint'(out_vld), 0);
    chk("R1 async clear out_quo", longint'(out_quo), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", longint'(out_quo), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule